// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Selectable Period Dividers

This block drives four single-bit pulse-width modulated pins and is programmed over a simple 32-bit register bus with a byte address, write data, a write strobe and a combinational read port. Time is generated by four independent 16-bit period dividers. Each divider counts input clocks up to its programmed period value and then emits a one-cycle tick. Each output channel owns an 8-bit phase counter that advances on the ticks of one divider. The channel picks that divider through a 2-bit selector, so one divider can drive several channels and any channel can borrow any divider.

A full output period is the divider value times 256 input clocks. The 8-bit level sets the high time in 1/256ths of that period. Every channel also has an output enable and a force-high bypass for a steady 100% output. Software reprograms a divider or a channel by writing its register. The new value acts at once: the running count restarts from zero and the unfinished period is dropped.

Top module: `pulse_mod_quad`

## Requirements
- R1: After reset every register reads zero and all four outputs are low.
- R2: Registers keep only their defined bits, and all other bits read zero. Output control at byte address 0x00 holds enables in bits 3:0 and bypasses in bits 11:8. Divider control at 0x04 holds divider run bits in bits 3:0. Period of divider k at 0x08+4k holds bits 15:0. Channel n setup at 0x18+4n holds the level in bits 7:0 and the divider selector in bits 9:8. Unmapped or misaligned addresses read zero and ignore writes.
- R3: A channel whose output enable is clear drives its pin low.
- R4: A channel with both output enable and bypass set drives its pin high constantly, whatever its level or divider. A bypass without an enable still gives low.
- R5: An enabled, non-bypassed channel with level 0 stays low.
- R6: With a running divider of period P and level L, the pin repeats every P×256 clocks and is high for exactly P×L of them.
- R7: A divider whose run bit is clear produces no ticks and holds its count at zero. The phase of any channel it drives stays frozen, so that channel's pin does not change.
- R8: A divider programmed with period 0 produces no ticks.
- R9: A channel counts only on the ticks of the divider named by its selector bits 9:8.
- R10: Writing a period register restarts that divider's count from zero. Writing a channel setup register restarts that channel's phase from zero. After back-to-back writes of period P and level L (L≥1) to a running divider and channel, the first high run lasts P×L−1 clocks. With P=1 it lasts L clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock; all counters advance on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, sampled on the rising clock edge |
| addr_i | input | 8 | Byte address for reads and writes |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Combinational read data for addr_i |
| pwm_o | output | 4 | One modulated output per channel |

## Verification
A wrong divider count shows up as a wrong high-time total over one full P×256 window, or as a first high run after reprogramming that is off by whole divider periods. A restart that is not taken changes that first run within P×L clocks of the write. A channel that listens to the wrong divider stays frozen, or runs at a foreign rate, once its own divider is stopped. That is visible within one period. A wrong register mask or decode is visible on the very next read of the affected address.

// File: rtl/pmq_pkg.sv
package pmq_pkg;

    // default geometry of the modulator
    localparam int unsigned PMQ_NCH     = 4;
    localparam int unsigned PMQ_DIV_W   = 16;
    localparam int unsigned PMQ_LVL_W   = 8;
    localparam int unsigned PMQ_BUS_W   = 32;
    localparam int unsigned PMQ_ADDR_W  = 8;
    // bit position of the first bypass bit in the output control word
    localparam int unsigned PMQ_BYP_POS = 8;

    // which register a bus address selects
    typedef enum logic [2:0] {
        SLOT_NONE,
        SLOT_CTRL_OUT,
        SLOT_CTRL_DIV,
        SLOT_PERIOD,
        SLOT_SETUP
    } slot_e;

endpackage

// File: rtl/pmq_regs.sv
module pmq_regs
    import pmq_pkg::*;
#(
    parameter int unsigned NCH     = PMQ_NCH,
    parameter int unsigned DIV_W   = PMQ_DIV_W,
    parameter int unsigned LVL_W   = PMQ_LVL_W,
    parameter int unsigned BUS_W   = PMQ_BUS_W,
    parameter int unsigned ADDR_W  = PMQ_ADDR_W,
    parameter int unsigned BYP_POS = PMQ_BYP_POS,
    parameter int unsigned SEL_W   = $clog2(NCH)
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             wr_en_i,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic [BUS_W-1:0]                 wr_data_i,
    output logic [BUS_W-1:0]                 rd_data_o,
    output logic [NCH-1:0]                   out_en_o,
    output logic [NCH-1:0]                   bypass_o,
    output logic [NCH-1:0]                   div_en_o,
    output logic [NCH-1:0][DIV_W-1:0]        limit_o,
    output logic [NCH-1:0][LVL_W-1:0]        level_o,
    output logic [NCH-1:0][SEL_W-1:0]        sel_o,
    output logic [NCH-1:0]                   limit_wr_o,
    output logic [NCH-1:0]                   level_wr_o
);

    // word indices of the register groups
    localparam int unsigned PERIOD_BASE = 2;
    localparam int unsigned SETUP_BASE  = PERIOD_BASE + NCH;
    localparam int unsigned WORD_END    = SETUP_BASE + NCH;

    typedef struct packed {
        logic [NCH-1:0]            out_en;
        logic [NCH-1:0]            bypass;
        logic [NCH-1:0]            div_en;
        logic [NCH-1:0][DIV_W-1:0] limit;
        logic [NCH-1:0][LVL_W-1:0] level;
        logic [NCH-1:0][SEL_W-1:0] sel;
    } regs_t;

    regs_t             st_d, st_q;
    slot_e             kind;
    logic [SEL_W-1:0]  idx;
    int unsigned       word;
    logic [BUS_W-1:0]  rd;
    logic [NCH-1:0]    limit_wr, level_wr;
    logic              unused_wdata;

    assign unused_wdata = ^wr_data_i;

    // address decode shared by the read and write paths
    always_comb begin
        kind = SLOT_NONE;
        idx  = '0;
        word = 32'(addr_i[ADDR_W-1:2]);
        if (addr_i[1:0] == 2'b00) begin
            if (word == 0) begin
                kind = SLOT_CTRL_OUT;
            end else if (word == 1) begin
                kind = SLOT_CTRL_DIV;
            end else if (word >= PERIOD_BASE && word < SETUP_BASE) begin
                kind = SLOT_PERIOD;
                idx  = SEL_W'(word - PERIOD_BASE);
            end else if (word >= SETUP_BASE && word < WORD_END) begin
                kind = SLOT_SETUP;
                idx  = SEL_W'(word - SETUP_BASE);
            end
        end
    end

    // next register state and restart strobes
    always_comb begin
        st_d     = st_q;
        limit_wr = '0;
        level_wr = '0;
        if (wr_en_i) begin
            case (kind)
                SLOT_CTRL_OUT: begin
                    st_d.out_en = wr_data_i[NCH-1:0];
                    st_d.bypass = wr_data_i[BYP_POS +: NCH];
                end
                SLOT_CTRL_DIV: begin
                    st_d.div_en = wr_data_i[NCH-1:0];
                end
                SLOT_PERIOD: begin
                    st_d.limit[idx] = wr_data_i[DIV_W-1:0];
                    limit_wr[idx]   = 1'b1;
                end
                SLOT_SETUP: begin
                    st_d.level[idx] = wr_data_i[LVL_W-1:0];
                    st_d.sel[idx]   = wr_data_i[LVL_W +: SEL_W];
                    level_wr[idx]   = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        rd = '0;
        case (kind)
            SLOT_CTRL_OUT: begin
                rd[NCH-1:0]       = st_q.out_en;
                rd[BYP_POS +: NCH] = st_q.bypass;
            end
            SLOT_CTRL_DIV: begin
                rd[NCH-1:0] = st_q.div_en;
            end
            SLOT_PERIOD: begin
                rd[DIV_W-1:0] = st_q.limit[idx];
            end
            SLOT_SETUP: begin
                rd[LVL_W-1:0]     = st_q.level[idx];
                rd[LVL_W +: SEL_W] = st_q.sel[idx];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o  = rd;
    assign out_en_o   = st_q.out_en;
    assign bypass_o   = st_q.bypass;
    assign div_en_o   = st_q.div_en;
    assign limit_o    = st_q.limit;
    assign level_o    = st_q.level;
    assign sel_o      = st_q.sel;
    assign limit_wr_o = limit_wr;
    assign level_wr_o = level_wr;

endmodule

// File: rtl/pmq_divider.sv
module pmq_divider
    import pmq_pkg::*;
#(
    parameter int unsigned DIV_W = PMQ_DIV_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] limit_i,
    input  logic             restart_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] count;
    } div_t;

    div_t st_d, st_q;
    logic at_wrap;
    logic live;

    always_comb begin
        st_d    = st_q;
        live    = run_i && (limit_i != '0) && !restart_i;
        at_wrap = (st_q.count == (limit_i - DIV_W'(1)));
        if (!live) begin
            // stopped, empty period or fresh period value: count rests at zero
            st_d.count = '0;
        end else if (at_wrap) begin
            st_d.count = '0;
        end else begin
            st_d.count = st_q.count + DIV_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = live && at_wrap;

endmodule

// File: rtl/pmq_channel.sv
module pmq_channel
    import pmq_pkg::*;
#(
    parameter int unsigned NCH   = PMQ_NCH,
    parameter int unsigned LVL_W = PMQ_LVL_W,
    parameter int unsigned SEL_W = $clog2(NCH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NCH-1:0]   ticks_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic             restart_i,
    input  logic             out_en_i,
    input  logic             bypass_i,
    output logic             pwm_o
);

    typedef struct packed {
        logic [LVL_W-1:0] phase;
    } chan_t;

    chan_t st_d, st_q;
    logic  step;

    always_comb begin
        st_d = st_q;
        step = ticks_i[sel_i];
        if (restart_i) begin
            st_d.phase = '0;
        end else if (step) begin
            st_d.phase = st_q.phase + LVL_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o = out_en_i && (bypass_i || (st_q.phase < level_i));

endmodule

// File: rtl/pulse_mod_quad.sv
module pulse_mod_quad
    import pmq_pkg::*;
#(
    parameter int unsigned NCH    = PMQ_NCH,
    parameter int unsigned DIV_W  = PMQ_DIV_W,
    parameter int unsigned LVL_W  = PMQ_LVL_W,
    parameter int unsigned BUS_W  = PMQ_BUS_W,
    parameter int unsigned ADDR_W = PMQ_ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wr_data_i,
    output logic [BUS_W-1:0]  rd_data_o,
    output logic [NCH-1:0]    pwm_o
);

    localparam int unsigned SEL_W = $clog2(NCH);

    logic [NCH-1:0]            out_en;
    logic [NCH-1:0]            bypass;
    logic [NCH-1:0]            div_en;
    logic [NCH-1:0][DIV_W-1:0] limit;
    logic [NCH-1:0][LVL_W-1:0] level;
    logic [NCH-1:0][SEL_W-1:0] sel;
    logic [NCH-1:0]            limit_wr;
    logic [NCH-1:0]            level_wr;
    logic [NCH-1:0]            tick;

    pmq_regs #(
        .NCH    (NCH),
        .DIV_W  (DIV_W),
        .LVL_W  (LVL_W),
        .BUS_W  (BUS_W),
        .ADDR_W (ADDR_W),
        .BYP_POS(PMQ_BYP_POS),
        .SEL_W  (SEL_W)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .out_en_o  (out_en),
        .bypass_o  (bypass),
        .div_en_o  (div_en),
        .limit_o   (limit),
        .level_o   (level),
        .sel_o     (sel),
        .limit_wr_o(limit_wr),
        .level_wr_o(level_wr)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_div
        pmq_divider #(
            .DIV_W(DIV_W)
        ) u_div (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .run_i    (div_en[k]),
            .limit_i  (limit[k]),
            .restart_i(limit_wr[k]),
            .tick_o   (tick[k])
        );
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        pmq_channel #(
            .NCH  (NCH),
            .LVL_W(LVL_W),
            .SEL_W(SEL_W)
        ) u_chan (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .ticks_i  (tick),
            .sel_i    (sel[n]),
            .level_i  (level[n]),
            .restart_i(level_wr[n]),
            .out_en_i (out_en[n]),
            .bypass_i (bypass[n]),
            .pwm_o    (pwm_o[n])
        );
    end

endmodule

// File: rtl/pmq_checker.sv
module pmq_checker #(
    parameter int unsigned NCH    = 4,
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned LVL_W  = 8,
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic                      wr_en_i,
    input logic [ADDR_W-1:0]         addr_i,
    input logic [BUS_W-1:0]          wr_data_i,
    input logic [BUS_W-1:0]          rd_data_i,
    input logic [NCH-1:0]            pwm_i,
    input logic [NCH-1:0]            out_en_i,
    input logic [NCH-1:0]            bypass_i,
    input logic [NCH-1:0]            div_en_i,
    input logic [NCH-1:0][DIV_W-1:0] limit_i,
    input logic [NCH-1:0][LVL_W-1:0] level_i,
    input logic [NCH-1:0]            tick_i
);

    localparam logic [ADDR_W-1:0] DIV_CTRL_ADDR = ADDR_W'(4);

    // R2: divider control reads back only its run bits
    p_div_ctrl_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(wr_en_i && addr_i == DIV_CTRL_ADDR) && addr_i == DIV_CTRL_ADDR
        |-> rd_data_i == BUS_W'($past(wr_data_i[NCH-1:0])));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        localparam logic [ADDR_W-1:0] SETUP_ADDR = ADDR_W'(4 * (2 + NCH + g));

        p_off_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !out_en_i[g] |-> !pwm_i[g]);

        p_bypass_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            out_en_i[g] && bypass_i[g] |-> pwm_i[g]);

        p_zero_level_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            out_en_i[g] && !bypass_i[g] && level_i[g] == '0 |-> !pwm_i[g]);

        p_idle_divider_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !div_en_i[g] |-> !tick_i[g]);

        p_empty_period_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            limit_i[g] == '0 |-> !tick_i[g]);

        p_restart_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            wr_en_i && addr_i == SETUP_ADDR && wr_data_i[LVL_W-1:0] != '0 && out_en_i[g]
            |=> pwm_i[g]);
    end

endmodule

bind pulse_mod_quad pmq_checker #(
    .NCH   (NCH),
    .DIV_W (DIV_W),
    .LVL_W (LVL_W),
    .BUS_W (BUS_W),
    .ADDR_W(ADDR_W)
) u_pmq_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wr_data_i(wr_data_i),
    .rd_data_i(rd_data_o),
    .pwm_i    (pwm_o),
    .out_en_i (out_en),
    .bypass_i (bypass),
    .div_en_i (div_en),
    .limit_i  (limit),
    .level_i  (level),
    .tick_i   (tick)
);

// File: tb/pulse_mod_quad_tb_top.sv
module pulse_mod_quad_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  pwm;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pulse_mod_quad dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .wr_en_i  (we),
        .addr_i   (addr),
        .wr_data_i(wdata),
        .rd_data_o(rdata),
        .pwm_o    (pwm)
    );

    typedef struct packed {
        logic [1:0]  ch;
        logic [1:0]  dv;
        logic [15:0] per;
        logic [7:0]  lvl;
        logic [31:0] exp_high;   // per * lvl high clocks per window
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 2'd0, 16'd1, 8'd64,  32'd64},
        '{2'd1, 2'd1, 16'd2, 8'd100, 32'd200},
        '{2'd2, 2'd3, 16'd1, 8'd255, 32'd255},
        '{2'd3, 2'd2, 16'd3, 8'd17,  32'd51},
        '{2'd0, 2'd2, 16'd2, 8'd128, 32'd256},
        '{2'd1, 2'd0, 16'd1, 8'd1,   32'd1},
        '{2'd2, 2'd1, 16'd3, 8'd200, 32'd600},
        '{2'd3, 2'd3, 16'd2, 8'd7,   32'd14}
    };

    function automatic logic [7:0] per_addr(input int k);
        return 8'(8 + 4 * k);
    endfunction

    function automatic logic [7:0] setup_addr(input int n);
        return 8'(24 + 4 * n);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the write
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        we    = 1'b1;
        @(negedge clk);
        we    = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic clear_all();
        bus_write(8'h00, 32'h0);
        bus_write(8'h04, 32'h0);
        for (int i = 0; i < 4; i++) begin
            bus_write(per_addr(i), 32'h0);
            bus_write(setup_addr(i), 32'h0);
        end
    endtask

    task automatic count_high(input int ch, input int cycles, output int unsigned cnt);
        cnt = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pwm[ch]) cnt++;
        end
    endtask

    task automatic count_toggles(input int ch, input int cycles, output int unsigned cnt);
        logic prev;
        cnt  = 0;
        prev = pwm[ch];
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pwm[ch] != prev) cnt++;
            prev = pwm[ch];
        end
    endtask

    // length of the high run starting in the current cycle
    task automatic first_run(input int ch, output int unsigned cnt);
        cnt = 0;
        #1;
        while (pwm[ch] && cnt < 5000) begin
            cnt++;
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0]  rv;
        int unsigned  c;

        repeat (3) @(negedge clk);
        check("R1 outputs in reset", 32'(pwm), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: everything reads zero after reset
        for (int a = 0; a < 48; a += 4) begin
            bus_read(8'(a), rv);
            check("R1 register reset value", rv, 32'h0);
        end
        check("R1 outputs after reset", 32'(pwm), 32'h0);
        @(negedge clk);

        // R2: masks, unmapped and misaligned addresses
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_read(8'h00, rv); check("R2 output control mask", rv, 32'h0000_0F0F);
        @(negedge clk);
        bus_write(8'h04, 32'hFFFF_FFF5);
        bus_read(8'h04, rv); check("R2 divider control mask", rv, 32'h0000_0005);
        @(negedge clk);
        bus_write(per_addr(2), 32'hABCD_FFFF);
        bus_read(per_addr(2), rv); check("R2 period mask", rv, 32'h0000_FFFF);
        @(negedge clk);
        bus_write(setup_addr(1), 32'hFFFF_FFFF);
        bus_read(setup_addr(1), rv); check("R2 setup mask", rv, 32'h0000_03FF);
        @(negedge clk);
        bus_write(8'h40, 32'hFFFF_FFFF);
        bus_read(8'h40, rv); check("R2 unmapped reads zero", rv, 32'h0);
        @(negedge clk);
        bus_write(8'h05, 32'hFFFF_FFFF);
        bus_read(8'h05, rv); check("R2 misaligned reads zero", rv, 32'h0);
        bus_read(8'h04, rv); check("R2 misaligned write ignored", rv, 32'h0000_0005);
        @(negedge clk);
        clear_all();

        // R3: disabled output stays low while its divider runs
        bus_write(8'h04, 32'hF);
        bus_write(per_addr(0), 32'd1);
        bus_write(setup_addr(0), 32'd128);
        count_high(0, 256, c); check("R3 disabled output low", c, 0);

        // R4: bypass with enable is high; bypass alone is low
        bus_write(8'h00, 32'h101);
        count_high(0, 256, c); check("R4 bypass high", c, 256);
        bus_write(8'h04, 32'h0);
        count_high(0, 256, c); check("R4 bypass high with divider stopped", c, 256);
        bus_write(8'h00, 32'h100);
        count_high(0, 256, c); check("R4 bypass without enable low", c, 0);

        // R5: level zero stays low
        bus_write(8'h04, 32'hF);
        bus_write(8'h00, 32'h1);
        bus_write(setup_addr(0), 32'd0);
        count_high(0, 512, c); check("R5 level zero low", c, 0);
        clear_all();

        // R6 / R9: table of period, level and divider choices
        bus_write(8'h04, 32'hF);
        bus_write(8'h00, 32'hF);
        foreach (VECS[i]) begin
            bus_write(per_addr(int'(VECS[i].dv)), 32'(VECS[i].per));
            bus_write(setup_addr(int'(VECS[i].ch)), {22'd0, VECS[i].dv, VECS[i].lvl});
            repeat (3) @(negedge clk);
            count_high(int'(VECS[i].ch), 256 * int'(VECS[i].per), c);
            check($sformatf("R6 R9 vector %0d high time", i), c, VECS[i].exp_high);
        end
        clear_all();

        // R9: channel 1 follows divider 2 only
        bus_write(8'h04, 32'h4);
        bus_write(per_addr(2), 32'd1);
        bus_write(8'h00, 32'h2);
        bus_write(setup_addr(1), {22'd0, 2'd2, 8'd50});
        repeat (2) @(negedge clk);
        count_high(1, 256, c); check("R9 selected running divider", c, 50);
        bus_write(setup_addr(1), {22'd0, 2'd1, 8'd50});
        count_high(1, 256, c); check("R9 selected stopped divider frozen", c, 256);
        clear_all();

        // R7: stopping a divider freezes the channel
        bus_write(8'h04, 32'h1);
        bus_write(per_addr(0), 32'd1);
        bus_write(8'h00, 32'h1);
        bus_write(setup_addr(0), 32'd10);
        repeat (37) @(negedge clk);
        bus_write(8'h04, 32'h0);
        count_toggles(0, 600, c); check("R7 stopped divider no toggles", c, 0);
        bus_write(setup_addr(0), 32'd10);
        count_high(0, 600, c); check("R7 fresh phase held high", c, 600);

        // R8: period zero gives no ticks
        bus_write(8'h04, 32'h1);
        bus_write(per_addr(0), 32'd0);
        bus_write(setup_addr(0), 32'd10);
        count_high(0, 600, c); check("R8 empty period held high", c, 600);

        // R10: back-to-back period and setup writes restart both counts
        bus_write(per_addr(0), 32'd4);
        bus_write(setup_addr(0), 32'd2);
        first_run(0, c); check("R10 first run with period 4 level 2", c, 7);
        repeat (5) @(negedge clk);
        bus_write(per_addr(0), 32'd1);
        bus_write(setup_addr(0), 32'd5);
        first_run(0, c); check("R10 first run with period 1 level 5", c, 5);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule